// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Adapter

This block sits between an asynchronous microprocessor bus and a chip's internal register file. It turns each host bus cycle into one single-cycle read or write strobe on a synchronous register interface, with a 5-bit register address and 8-bit data. The host bus can use either of two control styles, chosen by the strap `intel_i`. With `intel_i` high, separate active-low read and write strobes are used, along with an address-latch-enable and a ready output. With `intel_i` low, a direction input, an active-low data strobe, an active-low address strobe and an active-low acknowledge output are used.

A second strap, `mux_i`, selects where the address comes from. In non-multiplexed operation the address arrives on its own bus. In multiplexed operation the address shares the data bus and is captured with the address strobe. A third strap, `port_en_i`, turns the whole port on.

All bus control inputs pass through a two-flop synchronizer before any decision is taken. The address and data buses are sampled directly by the system clock. The host must therefore hold them stable while the synchronized strobes act on them. The register contents are outside this block. Read data comes back on `reg_rdata_i` in the same cycle as `reg_re_o`.

Top module: `hbus_adapter`

## Requirements
- R1: Each recognized bus cycle produces exactly one `reg_we_o` or `reg_re_o` pulse, one clock wide. The pulse is high in the cycle that follows the third rising clock edge at which the qualifying bus inputs are present, because the controls pass two synchronizer flops and one state register.
- R2: With `intel_i`=1, a cycle is recognized when `cs_ni`=0 together with `wr_ni`=0 (write) or `rd_ni`=0 (read). If both are low, read takes priority. `ds_ni`, `rw_i` and `as_ni` have no effect in this mode.
- R3: With `intel_i`=0, a cycle is recognized when `cs_ni`=0 and `ds_ni`=0. `rw_i`=1 selects a read and `rw_i`=0 selects a write. `wr_ni`, `rd_ni` and `ale_i` have no effect in this mode.
- R4: With `mux_i`=0, the register address is taken from `addr_i` in the clock edge that recognizes the cycle. Write data is taken from `data_i` in that same edge.
- R5: With `mux_i`=1, `data_i[4:0]` is latched when the synchronized address strobe ends. For `intel_i`=1 that is `ale_i` going from 1 to 0. For `intel_i`=0 that is `as_ni` going from 0 to 1. This latched value is the address of later cycles. The host holds the address on `data_i` for at least 3 clocks after the strobe ends.
- R6: Read data present on `reg_rdata_i` during the `reg_re_o` cycle is driven on `data_o`. `data_oe_o`=1 from the next cycle until the cycle ends. `data_oe_o` is 1 only during such a read with the synchronized `cs_ni` low.
- R7: With `intel_i`=1, `rdy_o` is 0 in the cycle of the read or write pulse and 1 otherwise. `ack_no` stays 1.
- R8: With `intel_i`=0, `ack_no` is 0 from the cycle after the pulse until the synchronized data strobe or chip select is released. `rdy_o` stays 1.
- R9: A strobe held low for many clocks yields one pulse only. A new cycle is recognized only after the previous one has been released.
- R10: With `port_en_i`=0, bus activity produces no pulse. `data_oe_o`=0, `rdy_o`=1 and `ack_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Strap: parallel port enabled when high |
| intel_i | input | 1 | Strap: 1 = separate read/write strobes, 0 = direction plus data strobe |
| mux_i | input | 1 | Strap: 1 = address on shared data bus |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low (intel_i=1) |
| rd_ni | input | 1 | Read strobe, active low (intel_i=1) |
| ale_i | input | 1 | Address latch enable, active high (intel_i=1) |
| ds_ni | input | 1 | Data strobe, active low (intel_i=0) |
| rw_i | input | 1 | Direction, 1 = read (intel_i=0) |
| as_ni | input | 1 | Address strobe, active low (intel_i=0) |
| addr_i | input | 5 | Separate address bus |
| data_i | input | 8 | Data bus inbound (address/data when multiplexed) |
| data_o | output | 8 | Read data outbound |
| data_oe_o | output | 1 | Data bus output enable |
| rdy_o | output | 1 | Ready, low while a cycle is being taken (intel_i=1) |
| ack_no | output | 1 | Acknowledge, active low (intel_i=0) |
| reg_addr_o | output | 5 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_rdata_i | input | 8 | Register read data, valid with reg_re_o |

## Verification
The bench targets the points where a wrong design visibly misbehaves. A strobe held for many clocks would give repeated pulses in a design that does not wait for release. An address strobe in multiplexed mode must be captured at its end: a latch on the wrong edge or the wrong polarity would write or read the wrong register. Signals from the unused control style are toggled with chip select low, and a design that decodes them would produce phantom pulses. With the port strapped off, a bus write is attempted and then read back after enabling, so a design that leaks cycles would corrupt the register.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_ACK  = 2'd3
  } hbus_state_e;

  // synchronized control vector bit positions
  localparam int unsigned CB_CS  = 6;
  localparam int unsigned CB_WR  = 5;
  localparam int unsigned CB_RD  = 4;
  localparam int unsigned CB_ALE = 3;
  localparam int unsigned CB_DS  = 2;
  localparam int unsigned CB_RW  = 1;
  localparam int unsigned CB_AS  = 0;
  localparam int unsigned CB_W   = 7;
  localparam logic [CB_W-1:0] CB_IDLE = 7'b111_0111;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= RST_VAL;
      else if (g == 0) q[g] <= d_i;
      else q[g] <= q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          intel_i,
  input  logic          mux_i,
  input  logic          ale_s_i,
  input  logic          as_n_s_i,
  input  logic [AW-1:0] bus_i,
  output logic [AW-1:0] alat_o
);
  logic strobe_act, strobe_d;

  assign strobe_act = intel_i ? ale_s_i : !as_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_d <= 1'b0;
      alat_o   <= '0;
    end else begin
      strobe_d <= strobe_act;
      // capture at end of the address phase
      if (mux_i && strobe_d && !strobe_act) alat_o <= bus_i;
    end
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_en_i,
  input  logic          intel_i,
  input  logic          mux_i,
  input  logic          cs_n_s_i,
  input  logic          wr_n_s_i,
  input  logic          rd_n_s_i,
  input  logic          ds_n_s_i,
  input  logic          rw_s_i,
  input  logic [AW-1:0] alat_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_o,
  output logic          ack_no,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o
);
  hbus_state_e state;
  logic strobe_on, req, dir_rd, rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  assign strobe_on = intel_i ? (!wr_n_s_i || !rd_n_s_i) : !ds_n_s_i;
  assign req       = !cs_n_s_i && strobe_on;
  assign dir_rd    = intel_i ? !rd_n_s_i : rw_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
    end else if (!port_en_i) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (req) begin
          state   <= dir_rd ? ST_RD : ST_WR;
          rd_q    <= dir_rd;
          addr_q  <= mux_i ? alat_i : addr_i;
          wdata_q <= data_i;
        end
        ST_WR: state <= ST_ACK;
        ST_RD: begin
          rdata_q <= reg_rdata_i;
          state   <= ST_ACK;
        end
        ST_ACK: if (!req) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reg_we_o    = port_en_i && (state == ST_WR);
  assign reg_re_o    = port_en_i && (state == ST_RD);
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign data_o      = rdata_q;
  assign data_oe_o   = port_en_i && (state == ST_ACK) && rd_q && !cs_n_s_i;
  assign rdy_o       = !(intel_i && port_en_i && (state == ST_WR || state == ST_RD));
  assign ack_no      = !(!intel_i && port_en_i && (state == ST_ACK));

  a_r1_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r1_re_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  a_r9_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> !$past(reg_we_o || reg_re_o, 2));
  a_r6_oe_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(reg_re_o));
  a_r6_oe_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> rdy_o);
  a_r7_hs_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rdy_o && !ack_no));
  a_r10_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (state == ST_IDLE));
endmodule

// File: rtl/hbus_adapter.sv
module hbus_adapter
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_en_i,
  input  logic          intel_i,
  input  logic          mux_i,
  input  logic          cs_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic          ale_i,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic          as_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_o,
  output logic          ack_no,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic [CB_W-1:0] ctl_raw, ctl_s;
  logic [AW-1:0]   alat;

  always_comb begin
    ctl_raw         = '0;
    ctl_raw[CB_CS]  = cs_ni;
    ctl_raw[CB_WR]  = wr_ni;
    ctl_raw[CB_RD]  = rd_ni;
    ctl_raw[CB_ALE] = ale_i;
    ctl_raw[CB_DS]  = ds_ni;
    ctl_raw[CB_RW]  = rw_i;
    ctl_raw[CB_AS]  = as_ni;
  end

  hbus_sync #(.W(CB_W), .STAGES(SYNC_STAGES), .RST_VAL(CB_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  hbus_addr_latch #(.AW(AW)) u_alat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .intel_i  (intel_i),
    .mux_i    (mux_i),
    .ale_s_i  (ctl_s[CB_ALE]),
    .as_n_s_i (ctl_s[CB_AS]),
    .bus_i    (data_i[AW-1:0]),
    .alat_o   (alat)
  );

  hbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .port_en_i   (port_en_i),
    .intel_i     (intel_i),
    .mux_i       (mux_i),
    .cs_n_s_i    (ctl_s[CB_CS]),
    .wr_n_s_i    (ctl_s[CB_WR]),
    .rd_n_s_i    (ctl_s[CB_RD]),
    .ds_n_s_i    (ctl_s[CB_DS]),
    .rw_s_i      (ctl_s[CB_RW]),
    .alat_i      (alat),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .reg_rdata_i (reg_rdata_i),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .rdy_o       (rdy_o),
    .ack_no      (ack_no),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o)
  );
endmodule

// File: tb/hbus_adapter_test.sv
`timescale 1ns/1ps
module hbus_adapter_test;
  logic clk = 0, rst_n = 0;
  logic port_en = 1, intel = 1, mux = 0;
  logic cs_n = 1, wr_n = 1, rd_n = 1, ale = 1, ds_n = 1, rw = 1, as_n = 1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, rdata, wdata;
  logic oe, rdy, ack_n, we, re;
  logic [4:0] raddr;
  logic [7:0] mem [32];
  int errors = 0, checks = 0, cyc = 0, pulses = 0;
  logic [7:0] seen;
  bit seen_v;

  always #2.5 clk = ~clk;

  hbus_adapter uut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .intel_i(intel), .mux_i(mux),
    .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n), .ale_i(ale), .ds_ni(ds_n), .rw_i(rw),
    .as_ni(as_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .rdy_o(rdy), .ack_no(ack_n), .reg_addr_o(raddr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  assign rdata = mem[raddr];
  always @(posedge clk) if (we) mem[raddr] <= wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: two-deep delay line of controls, then cycle phases
  logic [6:0] p1 = 7'b1110111, p2 = 7'b1110111;
  int mst = 0;  // 0 idle 1 write pulse 2 read pulse 3 held
  bit m_rd = 0, m_sd = 0;
  logic [4:0] m_addr = 0, m_alat = 0;
  logic [7:0] m_wd = 0, m_rdat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 7'b1110111; p2 = 7'b1110111; mst = 0; m_rd = 0; m_sd = 0;
      m_addr = 0; m_alat = 0; m_wd = 0; m_rdat = 0;
    end else begin
      bit s_cs, s_wr, s_rd, s_ale, s_ds, s_rw, s_as, on, act, srt;
      {s_cs, s_wr, s_rd, s_ale, s_ds, s_rw, s_as} = p2;
      on  = intel ? (!s_wr || !s_rd) : !s_ds;
      act = !s_cs && on;
      srt = intel ? s_ale : !s_as;
      if (!port_en) mst = 0;
      else if (mst == 0) begin
        if (act) begin
          m_rd = intel ? !s_rd : s_rw;
          mst = m_rd ? 2 : 1;
          m_addr = mux ? m_alat : addr;
          m_wd = din;
        end
      end else if (mst == 1) mst = 3;
      else if (mst == 2) begin m_rdat = rdata; mst = 3; end
      else if (!act) mst = 0;
      if (mux && m_sd && !srt) m_alat = din[4:0];
      m_sd = srt;
      p2 = p1;
      p1 = {cs_n, wr_n, rd_n, ale, ds_n, rw, as_n};
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit ewe, ere, eoe;
    ewe = port_en && mst == 1;
    ere = port_en && mst == 2;
    eoe = port_en && mst == 3 && m_rd && !p2[6];
    chk("R1 write pulse", we, ewe);
    chk("R1 read pulse", re, ere);
    chk("R6 output enable", oe, eoe);
    chk("R7 ready", rdy, !(intel && port_en && (mst == 1 || mst == 2)));
    chk("R8 acknowledge", ack_n, !(!intel && port_en && mst == 3));
    if (ewe || ere) chk(mux ? "R5 address" : "R4 address", raddr, m_addr);
    if (ewe) chk("R4 write data", wdata, m_wd);
    if (eoe) chk("R6 read data", dout, m_rdat);
    if (we || re) pulses++;
    if (oe) begin seen = dout; seen_v = 1; end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle_lines();
    cs_n = 1; wr_n = 1; rd_n = 1; ds_n = 1; rw = 1; as_n = 1;
    ale = (intel && !mux);
  endtask

  task automatic bus_op(input bit is_rd, input logic [4:0] a, input logic [7:0] d,
                        input int hold);
    if (mux) begin
      din = {3'b000, a};
      if (intel) ale = 1; else as_n = 0;
      step(3);
      if (intel) ale = 0; else as_n = 1;
      step(4);
    end else addr = a;
    din = is_rd ? 8'h00 : d;
    cs_n = 0;
    if (intel) begin if (is_rd) rd_n = 0; else wr_n = 0; end
    else begin rw = is_rd; ds_n = 0; end
    step(hold);
    idle_lines();
    step(5);
  endtask

  task automatic rd_expect(input string req, input logic [4:0] a, input logic [7:0] exp);
    seen_v = 0;
    bus_op(1, a, 8'h00, 8);
    chk({req, " read seen"}, seen_v, 1);
    chk({req, " read value"}, seen, exp);
  endtask

  task automatic set_mode(input bit i, input bit m);
    intel = i; mux = m; idle_lines(); step(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 7 + 3);
    step(3);
    chk("R7 reset ready", rdy, 1);
    chk("R8 reset ack", ack_n, 1);
    chk("R6 reset oe", oe, 0);
    rst_n = 1;
    step(3);

    // R2 R4 separate buses, strobe style
    set_mode(1, 0);
    bus_op(0, 5'd3, 8'hA5, 8);
    chk("R2 write stored", mem[3], 8'hA5);
    rd_expect("R2", 5'd3, 8'hA5);
    rd_expect("R4", 5'd20, 8'(20 * 7 + 3));

    // R2 other-style lines ignored
    pulses = 0;
    cs_n = 0; ds_n = 0; rw = 0; as_n = 0; step(10);
    idle_lines(); step(5);
    chk("R2 foreign lines no pulse", pulses, 0);

    // R9 long strobe
    pulses = 0;
    bus_op(0, 5'd7, 8'h3C, 40);
    chk("R9 single pulse", pulses, 1);
    chk("R9 write stored", mem[7], 8'h3C);

    // R5 multiplexed, strobe style
    set_mode(1, 1);
    bus_op(0, 5'd17, 8'h5A, 8);
    chk("R5 mux write stored", mem[17], 8'h5A);
    rd_expect("R5", 5'd17, 8'h5A);

    // R3 direction style, separate buses
    set_mode(0, 0);
    bus_op(0, 5'd9, 8'hC3, 8);
    chk("R3 write stored", mem[9], 8'hC3);
    rd_expect("R3", 5'd9, 8'hC3);
    pulses = 0;
    cs_n = 0; wr_n = 0; rd_n = 0; ale = 1; step(10);
    idle_lines(); step(5);
    chk("R3 foreign lines no pulse", pulses, 0);

    // R5 multiplexed, direction style
    set_mode(0, 1);
    bus_op(0, 5'd30, 8'h81, 8);
    chk("R5 mux dir write stored", mem[30], 8'h81);
    rd_expect("R5 dir", 5'd30, 8'h81);

    // R10 port off
    set_mode(1, 0);
    port_en = 0; step(2);
    pulses = 0;
    bus_op(0, 5'd3, 8'h11, 8);
    chk("R10 no pulse", pulses, 0);
    chk("R10 ready idle", rdy, 1);
    port_en = 1; step(3);
    rd_expect("R10", 5'd3, 8'hA5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule